// File: doc/BRIEF.md
# Clock Wake-Up and Divider Controller

This block keeps the core clock enable held low after a start-up or wake-up event until the selected oscillator has had time to settle. How long it waits depends on the oscillator kind chosen by a 3-bit source code. A crystal first counts a fixed number of oscillator cycles and then waits a window of external microsecond ticks. The RC source waits for ticks only. The watchdog and external sources count cycles only. The whole block runs on the oscillator clock. The microsecond window is taken at its upper bound, so settling is always complete when the wait ends.

When the wait is over, `clk_ready` asserts and the block starts issuing a one-cycle core clock enable. Its rate comes from an 8-bit divide register. A value N from 1 to 255 gives one enable every 2·N oscillator cycles. A value of 0 gives an enable on every cycle. Software may rewrite the divider while the block is running. The new ratio is picked up only at an enable boundary, so the period in progress always completes. A low-power flag is cleared by reset and changes only through its own write port.

The settle sequencer has four states:
- **LOAD** latches the source kind and clears the counter. It goes to CYCLES for crystal, watchdog and external sources, and to MICRO for RC.
- **CYCLES** counts oscillator cycles. When the count ends it goes to MICRO for a crystal, otherwise to READY.
- **MICRO** counts tick pulses and goes to READY on the last one.
- **READY** holds.

A sampled `wake_req` sends every state, READY included, back to LOAD. Reset also enters LOAD.

Top module: `clk_wake_div`

## Requirements
- R1: While reset is low, `clk_ready`, `core_en` and `low_power` are 0. After reset releases, the delay for the present `src_sel` runs. With code 100, `clk_ready` is still 0 at the 32nd rising edge after release and is 1 after the 33rd.
- R2: Codes 000, 001 and 010 select a crystal. Timing starts at the edge that samples `wake_req`. One load cycle follows, then 1024 oscillator cycles during which `us_tick` is ignored, then 100 `us_tick` pulses. `clk_ready` becomes 1 after the edge that samples the 100th pulse.
- R3: Code 011 selects the RC oscillator. One load cycle is followed by 300 `us_tick` pulses, with no cycle-count phase. `clk_ready` is still 0 after 299 pulses and becomes 1 after the 300th.
- R4: Codes 100 and 101, and the unused codes 110 and 111, count exactly 32 cycles. `clk_ready` is 0 at the 32nd edge after the wake-sampling edge and 1 after the 33rd.
- R5: `core_en` is 0 whenever `clk_ready` is 0. In the cycle after `wake_req` is sampled, `clk_ready` is 0.
- R6: A `wake_req` that arrives during a delay restarts the full delay from LOAD.
- R7: With divide value N in 1..255, `core_en` is high for one cycle out of every 2·N. This includes the largest period, 510.
- R8: With divide value 0, `core_en` is 1 in every cycle that `clk_ready` is 1.
- R9: A divide value written through `div_we` takes effect only at the next `core_en` boundary. The period already in progress completes at its old length.
- R10: `low_power` is 0 after every reset. It changes only in the cycle after `lp_we`, when it takes the value of `lp_wdata`.
- R11: Once `clk_ready` is 1, it stays 1 until the next `wake_req`. Changes on `src_sel` have no effect while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_req | input | 1 | Starts or restarts the settle delay |
| src_sel | input | 3 | Oscillator source code, latched in LOAD |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| div_we | input | 1 | Write strobe for the divide register |
| div_wdata | input | 8 | New divide value N |
| lp_we | input | 1 | Write strobe for the low-power flag |
| lp_wdata | input | 1 | New low-power flag value |
| clk_ready | output | 1 | Settle delay complete |
| core_en | output | 1 | Divided core clock enable |
| low_power | output | 1 | Software low-power flag |

## Verification
The hardest case to reach is a crystal source at the exact point where the cycle count hands over to the tick count. Ticks arriving in that window must not count. The stimulus holds `us_tick` high for the whole 1025-cycle load-and-count phase, including the handover edge, then drops it. It then issues 99 separated tick pulses and checks that `clk_ready` is still 0, and checks that it rises on the 100th. A second difficult case is a divider rewrite in the middle of a period. The bench synchronizes to an enable, writes a new value two cycles later, and checks that the gap still spans the old period before the new one applies.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    typedef enum logic [1:0] {
        SW_LOAD,
        SW_CYCLES,
        SW_MICRO,
        SW_READY
    } settle_state_t;

    typedef enum logic [1:0] {
        SRC_CRYSTAL,
        SRC_RC,
        SRC_DIRECT
    } src_kind_t;

    // 000/001/010 crystal, 011 RC, everything else counted as direct clock
    function automatic src_kind_t decode_src(input logic [2:0] code);
        src_kind_t kind;
        case (code)
            3'b000, 3'b001, 3'b010: kind = SRC_CRYSTAL;
            3'b011:                 kind = SRC_RC;
            default:                kind = SRC_DIRECT;
        endcase
        return kind;
    endfunction

endpackage

// File: rtl/cwd_settle_fsm.sv
module cwd_settle_fsm
    import cwd_pkg::*;
#(
    parameter int XTAL_CYC   = 1024,
    parameter int XTAL_US    = 100,
    parameter int RC_US      = 300,
    parameter int DIRECT_CYC = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake,
    input  logic [2:0] src_sel,
    input  logic       tick,
    output logic       ready
);
    localparam int MAX_A = (XTAL_CYC > DIRECT_CYC) ? XTAL_CYC : DIRECT_CYC;
    localparam int MAX_B = (XTAL_US > RC_US) ? XTAL_US : RC_US;
    localparam int MAXV  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAXV + 1);

    settle_state_t state, nxt;
    src_kind_t     kind;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cyc_last;
    logic [CNT_W-1:0] us_last;

    always_comb begin
        cyc_last = (kind == SRC_CRYSTAL) ? CNT_W'(XTAL_CYC - 1) : CNT_W'(DIRECT_CYC - 1);
        us_last  = (kind == SRC_CRYSTAL) ? CNT_W'(XTAL_US - 1)  : CNT_W'(RC_US - 1);
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            SW_LOAD:   nxt = (decode_src(src_sel) == SRC_RC) ? SW_MICRO : SW_CYCLES;
            SW_CYCLES: if (cnt == cyc_last)
                           nxt = (kind == SRC_CRYSTAL) ? SW_MICRO : SW_READY;
            SW_MICRO:  if (tick && cnt == us_last) nxt = SW_READY;
            SW_READY:  nxt = SW_READY;
        endcase
        if (wake) nxt = SW_LOAD;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SW_LOAD;
        else        state <= nxt;
    end

    // counter and latched source kind
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            kind <= SRC_DIRECT;
        end else if (wake) begin
            cnt <= '0;
        end else begin
            unique case (state)
                SW_LOAD: begin
                    cnt  <= '0;
                    kind <= decode_src(src_sel);
                end
                SW_CYCLES: cnt <= (cnt == cyc_last) ? '0 : cnt + 1'b1;
                SW_MICRO:  if (tick) cnt <= cnt + 1'b1;
                SW_READY:  cnt <= '0;
            endcase
        end
    end

    // output process
    always_comb begin
        ready = (state == SW_READY);
    end

endmodule

// File: rtl/cwd_divider.sv
module cwd_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_value,
    output logic             en,
    output logic [DIV_W-1:0] active_div
);
    localparam int PER_W = DIV_W + 1;

    logic [PER_W-1:0] cnt;
    logic [DIV_W-1:0] cur_n;
    logic [PER_W-1:0] last;
    logic             boundary;

    always_comb begin
        last     = {cur_n, 1'b0} - PER_W'(1);
        boundary = (cur_n == '0) || (cnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            cur_n <= '0;
        end else if (!run || boundary) begin
            cnt   <= '0;
            cur_n <= div_value;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        en         = run && boundary;
        active_div = cur_n;
    end

endmodule

// File: rtl/clk_wake_div.sv
module clk_wake_div #(
    parameter int XTAL_CYC   = 1024,
    parameter int XTAL_US    = 100,
    parameter int RC_US      = 300,
    parameter int DIRECT_CYC = 32,
    parameter int DIV_W      = 8
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             wake_req,
    input  logic [2:0]       src_sel,
    input  logic             us_tick,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             lp_we,
    input  logic             lp_wdata,
    output logic             clk_ready,
    output logic             core_en,
    output logic             low_power
);
    logic [DIV_W-1:0] div_reg;
    logic [DIV_W-1:0] active_div;
    logic             lp_q;

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            div_reg <= '0;
            lp_q    <= 1'b0;
        end else begin
            if (div_we) div_reg <= div_wdata;
            if (lp_we)  lp_q    <= lp_wdata;
        end
    end

    cwd_settle_fsm #(
        .XTAL_CYC  (XTAL_CYC),
        .XTAL_US   (XTAL_US),
        .RC_US     (RC_US),
        .DIRECT_CYC(DIRECT_CYC)
    ) u_settle (
        .clk    (osc_clk),
        .rst_n  (rst_n),
        .wake   (wake_req),
        .src_sel(src_sel),
        .tick   (us_tick),
        .ready  (clk_ready)
    );

    cwd_divider #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk       (osc_clk),
        .rst_n     (rst_n),
        .run       (clk_ready),
        .div_value (div_reg),
        .en        (core_en),
        .active_div(active_div)
    );

    assign low_power = lp_q;

endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wake_req,
    input logic             lp_we,
    input logic             clk_ready,
    input logic             core_en,
    input logic             low_power,
    input logic [DIV_W-1:0] active_div
);
    assert_en_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> clk_ready);

    assert_wake_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !clk_ready);

    assert_ready_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_ready && !wake_req) |=> clk_ready);

    assert_lp_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_we |=> $stable(low_power));

    assert_nodiv_every_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_ready && active_div == '0) |-> core_en);

endmodule

bind clk_wake_div cwd_checker #(.DIV_W(DIV_W)) u_chk (
    .clk       (osc_clk),
    .rst_n     (rst_n),
    .wake_req  (wake_req),
    .lp_we     (lp_we),
    .clk_ready (clk_ready),
    .core_en   (core_en),
    .low_power (low_power),
    .active_div(active_div)
);

// File: tb/clk_wake_div_tb.sv
module clk_wake_div_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       osc_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake_req = 1'b0;
    logic [2:0] src_sel = 3'b100;
    logic       us_tick = 1'b0;
    logic       div_we = 1'b0;
    logic [7:0] div_wdata = 8'd0;
    logic       lp_we = 1'b0;
    logic       lp_wdata = 1'b0;
    logic       clk_ready, core_en, low_power;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) osc_clk = ~osc_clk;

    clk_wake_div u_dut (
        .osc_clk(osc_clk), .rst_n(rst_n), .wake_req(wake_req), .src_sel(src_sel),
        .us_tick(us_tick), .div_we(div_we), .div_wdata(div_wdata),
        .lp_we(lp_we), .lp_wdata(lp_wdata),
        .clk_ready(clk_ready), .core_en(core_en), .low_power(low_power)
    );

    always @(posedge osc_clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            bad++;
            total++;
            $display("FAIL watchdog: act=%0d exp<=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input logic cond, input string req, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge osc_clk);
    endtask

    task automatic do_wake(input logic [2:0] s);
        src_sel  = s;
        wake_req = 1'b1;
        cyc(1);
        wake_req = 1'b0;
    endtask

    task automatic pulses(input int n);
        repeat (n) begin
            us_tick = 1'b1;
            cyc(1);
            us_tick = 1'b0;
            cyc(1);
        end
    endtask

    task automatic write_div(input logic [7:0] v);
        div_we    = 1'b1;
        div_wdata = v;
        cyc(1);
        div_we    = 1'b0;
    endtask

    task automatic sync_en();
        int g = 0;
        while (!core_en && g < 2000) begin
            cyc(1);
            g++;
        end
    endtask

    task automatic gap(output int g);
        g = 0;
        do begin
            cyc(1);
            g++;
        end while (!core_en && g < 2000);
    endtask

    // direct-clock timing: 32 low, 33rd high, no enable during wait
    task automatic expect_direct(input string req);
        int en_seen = 0;
        for (int i = 0; i < 32; i++) begin
            cyc(1);
            if (core_en) en_seen++;
        end
        chk(clk_ready == 1'b0, req, clk_ready, 0);
        chk(en_seen == 0, "R5", en_seen, 0);
        cyc(1);
        chk(clk_ready == 1'b1, req, clk_ready, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        src_sel = 3'b100;
        cyc(3);
        chk(clk_ready == 0 && core_en == 0 && low_power == 0, "R1", {clk_ready, core_en, low_power}, 0);
        rst_n = 1'b1;
        expect_direct("R1");
    endtask

    task automatic t_direct();
        do_wake(3'b101);
        expect_direct("R4");
        do_wake(3'b110);
        expect_direct("R4");
        do_wake(3'b111);
        expect_direct("R4");
    endtask

    task automatic t_crystal(input logic [2:0] s);
        src_sel = s;
        wake_req = 1'b1;
        cyc(1);
        wake_req = 1'b0;
        us_tick = 1'b1;        // ticks held through load and count phase: ignored
        cyc(1025);
        us_tick = 1'b0;
        chk(clk_ready == 1'b0, "R2", clk_ready, 0);
        pulses(99);
        chk(clk_ready == 1'b0, "R2", clk_ready, 0);
        us_tick = 1'b1;
        cyc(1);
        us_tick = 1'b0;
        chk(clk_ready == 1'b1, "R2", clk_ready, 1);
    endtask

    task automatic t_rc();
        do_wake(3'b011);
        cyc(1);
        pulses(299);
        chk(clk_ready == 1'b0, "R3", clk_ready, 0);
        us_tick = 1'b1;
        cyc(1);
        us_tick = 1'b0;
        chk(clk_ready == 1'b1, "R3", clk_ready, 1);
    endtask

    task automatic t_restart();
        do_wake(3'b100);
        cyc(20);
        chk(clk_ready == 1'b0, "R6", clk_ready, 0);
        do_wake(3'b100);
        expect_direct("R6");
    endtask

    task automatic t_wake_drop();
        // running with ready high: wake drops it next cycle
        wake_req = 1'b1;
        cyc(1);
        wake_req = 1'b0;
        chk(clk_ready == 1'b0 && core_en == 1'b0, "R5", {clk_ready, core_en}, 0);
        expect_direct("R5");
    endtask

    task automatic t_div();
        int g;
        int ones = 0;
        write_div(8'd0);
        for (int i = 0; i < 10; i++) begin
            cyc(1);
            if (core_en) ones++;
        end
        chk(ones == 10, "R8", ones, 10);
        write_div(8'd3);
        sync_en();
        for (int i = 0; i < 3; i++) begin
            gap(g);
            chk(g == 6, "R7", g, 6);
        end
        write_div(8'd255);
        sync_en();
        gap(g);
        chk(g == 510, "R7", g, 510);
        write_div(8'd1);
        sync_en();
        gap(g);
        chk(g == 2, "R7", g, 2);
    endtask

    task automatic t_midchange();
        int g = 0;
        int g2;
        write_div(8'd3);
        sync_en();
        sync_en();
        gap(g2);
        cyc(2);
        g = 2;
        write_div(8'd1);
        g++;
        while (!core_en && g < 2000) begin
            cyc(1);
            g++;
        end
        chk(g == 6, "R9", g, 6);
        gap(g2);
        chk(g2 == 2, "R9", g2, 2);
    endtask

    task automatic t_hold();
        int en_cnt = 0;
        src_sel = 3'b011;
        for (int i = 0; i < 50; i++) begin
            cyc(1);
            if (!clk_ready) en_cnt = -1000;
            if (core_en) en_cnt++;
        end
        chk(clk_ready == 1'b1 && en_cnt == 25, "R11", en_cnt, 25);
    endtask

    task automatic t_lp();
        chk(low_power == 1'b0, "R10", low_power, 0);
        lp_wdata = 1'b1;
        cyc(1);
        chk(low_power == 1'b0, "R10", low_power, 0);
        lp_we = 1'b1;
        cyc(1);
        lp_we = 1'b0;
        lp_wdata = 1'b0;
        chk(low_power == 1'b1, "R10", low_power, 1);
        do_wake(3'b100);
        cyc(5);
        chk(low_power == 1'b1, "R10", low_power, 1);
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        chk(low_power == 1'b0, "R10", low_power, 0);
        lp_wdata = 1'b1;
        lp_we = 1'b1;
        cyc(1);
        lp_we = 1'b0;
        lp_wdata = 1'b0;
        lp_we = 1'b1;
        cyc(1);
        lp_we = 1'b0;
        chk(low_power == 1'b0, "R10", low_power, 0);
        cyc(40);
    endtask

    initial begin
        t_reset();
        t_direct();
        t_crystal(3'b010);
        t_crystal(3'b000);
        t_rc();
        t_restart();
        t_wake_drop();
        t_div();
        t_midchange();
        t_hold();
        t_lp();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule